// File: doc/BRIEF.md
# Memory Write Protection Unit

This unit sits on the write path between a processor and its memory and decides, every cycle, whether a requested write may reach the memory array. It holds two protection registers. The first is a coarse region map. It has one bit per 512 KB region of the lowest 4 MB, and each region is 32 banks of 16 KB. The second is a fine page guard over the first 4 KB of one system bank. That area is split into sixteen 256-byte pages.

A write to a region whose map bit is clear is dropped without any notice. A write to a guarded page whose guard bit is clear is also dropped, and it latches a sticky violation flag that drives an interrupt request. Privileged system code clears guard bits while it runs and restores them on exit. The hardware forces the page guard back to fully writable on reset, on every interrupt entry and on every restart-instruction entry. Untrusted code therefore always starts with the guard open, and the guard only protects the pages that trusted code has closed.

The memory write enable is combinational, so a blocked write costs no extra cycle. Register updates, guard re-arming and the flag all take effect on the next clock edge.

Top module: `mem_write_guard`

## Requirements
- R1: `mem_we` is never high unless `wr_req` is high in the same cycle.
- R2: The region map resets to 8'hFF. Map bit n governs banks whose top three bank bits (`bank[7:5]`) equal n. A set bit permits writes and a clear bit makes the region read-only. A write through `map_we` takes effect from the next cycle.
- R3: A write into a read-only region holds `mem_we` low and does not set `viol_flag`.
- R4: The guard window is bank 8'h20 with `offset[13:12]` equal to 0, and the page is `offset[11:8]`. Inside the window, guard bit p set permits writes to page p. Writes outside the window are not affected by the guard.
- R5: The page guard resets to 16'hFFFF. A pulse on `irq_entry` or `rst_entry` forces it to 16'hFFFF at the next edge, and this wins over a `guard_we` write in the same cycle. Otherwise `guard_we` loads `guard_wdata`.
- R6: A write in a writable region to a window page whose guard bit is clear holds `mem_we` low in that cycle. It sets `viol_flag` and `irq` from the next cycle.
- R7: `viol_flag` stays set until a cycle with `flag_ack` high clears it at the next edge. A new violation in the same cycle as `flag_ack` keeps the flag set. `irq` always equals `viol_flag`.
- R8: Blocking is per cycle. A permitted write in the cycle right after a blocked one drives `mem_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank | input | 8 | Physical bank number of the access |
| offset | input | 14 | Address offset within the 16 KB bank |
| wr_req | input | 1 | Processor write strobe |
| map_we | input | 1 | Load the region map |
| map_wdata | input | 8 | New region map value |
| guard_we | input | 1 | Load the page guard |
| guard_wdata | input | 16 | New page guard value |
| irq_entry | input | 1 | Pulse on interrupt acknowledge |
| rst_entry | input | 1 | Pulse on restart-instruction execution |
| flag_ack | input | 1 | Write-one-to-clear for the violation flag |
| mem_we | output | 1 | Write enable forwarded to memory |
| irq | output | 1 | Interrupt request from a page violation |
| viol_flag | output | 1 | Violation status bit |

## Verification
The assertions check the following on every cycle:
- no write enable appears without a request;
- read-only regions never pass a write;
- a guard violation both blocks the write and sets the flag one cycle later;
- the flag holds until it is acknowledged;
- both entry pulses re-open the guard.

Some behaviours appear only in the bench's scenarios:
- the exact bit-to-bank and bit-to-page decoding, including the upper offset bits that place an address outside the window;
- the priority of entry pulses over a guard load, and of a new violation over an acknowledge;
- the ability to write again in the cycle right after a block.

// File: rtl/mem_write_guard.sv
module mem_write_guard #(
  parameter int BANK_W   = 8,
  parameter int OFS_W    = 14,
  parameter int REGIONS  = 8,
  parameter int PAGES    = 16,
  parameter int PAGE_LSB = 8,
  parameter logic [BANK_W-1:0] SYS_BANK = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFS_W-1:0]   offset,
  input  logic               wr_req,
  input  logic               map_we,
  input  logic [REGIONS-1:0] map_wdata,
  input  logic               guard_we,
  input  logic [PAGES-1:0]   guard_wdata,
  input  logic               irq_entry,
  input  logic               rst_entry,
  input  logic               flag_ack,
  output logic               mem_we,
  output logic               irq,
  output logic               viol_flag
);
  localparam int RSEL_W  = $clog2(REGIONS);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int WIN_TOP = PAGE_LSB + PAGE_W;

  logic [REGIONS-1:0] ro_map;
  logic [PAGES-1:0]   guard;
  logic               flag;

  wire [RSEL_W-1:0] region    = bank[BANK_W-1 -: RSEL_W];
  wire              region_ok = ro_map[region];
  wire              in_window = (bank == SYS_BANK) && (offset[OFS_W-1:WIN_TOP] == '0);
  wire [PAGE_W-1:0] page      = offset[WIN_TOP-1:PAGE_LSB];
  wire              page_ok   = !in_window || guard[page];
  wire              violation = wr_req && region_ok && !page_ok;
  wire              unused_ok = &{1'b0, offset[PAGE_LSB-1:0]};

  assign mem_we    = wr_req && region_ok && page_ok;
  assign irq       = flag;
  assign viol_flag = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ro_map <= '1;
      guard  <= '1;
      flag   <= 1'b0;
    end else begin
      if (map_we) ro_map <= map_wdata;
      if (irq_entry || rst_entry) guard <= '1;
      else if (guard_we)          guard <= guard_wdata;
      if (violation)     flag <= 1'b1;
      else if (flag_ack) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_write_guard_chk.sv
module mem_write_guard_chk #(
  parameter int BANK_W   = 8,
  parameter int OFS_W    = 14,
  parameter int REGIONS  = 8,
  parameter int PAGES    = 16,
  parameter int PAGE_LSB = 8,
  parameter logic [BANK_W-1:0] SYS_BANK = 8'h20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [BANK_W-1:0]  bank,
  input logic [OFS_W-1:0]   offset,
  input logic               wr_req,
  input logic               irq_entry,
  input logic               rst_entry,
  input logic               flag_ack,
  input logic               mem_we,
  input logic               irq,
  input logic               viol_flag,
  input logic [REGIONS-1:0] ro_map,
  input logic [PAGES-1:0]   guard
);
  localparam int RSEL_W  = $clog2(REGIONS);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int WIN_TOP = PAGE_LSB + PAGE_W;

  wire ro_hit  = !ro_map[bank[BANK_W-1 -: RSEL_W]];
  wire pg_hit  = (bank == SYS_BANK) && (offset[OFS_W-1:WIN_TOP] == '0)
                 && !guard[offset[WIN_TOP-1:PAGE_LSB]];

  AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_req); // R1
  AST_RO_REGION_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && ro_hit) |-> !mem_we); // R3
  AST_GUARD_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry || rst_entry) |=> (guard == '1)); // R5
  AST_PAGE_VIOLATION_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !ro_hit && pg_hit) |-> !mem_we); // R6
  AST_PAGE_VIOLATION_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !ro_hit && pg_hit) |=> viol_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !flag_ack) |=> viol_flag); // R7
  AST_IRQ_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> irq); // R7
endmodule

bind mem_write_guard mem_write_guard_chk #(
  .BANK_W(BANK_W), .OFS_W(OFS_W), .REGIONS(REGIONS),
  .PAGES(PAGES), .PAGE_LSB(PAGE_LSB), .SYS_BANK(SYS_BANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank(bank), .offset(offset), .wr_req(wr_req),
  .irq_entry(irq_entry), .rst_entry(rst_entry), .flag_ack(flag_ack),
  .mem_we(mem_we), .irq(irq), .viol_flag(viol_flag),
  .ro_map(ro_map), .guard(guard)
);

// File: tb/mem_write_guard_bench.sv
`timescale 1ns/1ps
module mem_write_guard_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bank = 0;
  logic [13:0] offset = 0;
  logic        wr_req = 0, map_we = 0, guard_we = 0;
  logic [7:0]  map_wdata = 0;
  logic [15:0] guard_wdata = 0;
  logic        irq_entry = 0, rst_entry = 0, flag_ack = 0;
  logic        mem_we, irq, viol_flag;

  int checks = 0, errors = 0;
  logic [7:0]  m_map;
  logic [15:0] m_guard;
  logic        m_flag;

  always #10 clk = ~clk;

  mem_write_guard u_mem_write_guard (
    .clk(clk), .rst_n(rst_n), .bank(bank), .offset(offset), .wr_req(wr_req),
    .map_we(map_we), .map_wdata(map_wdata), .guard_we(guard_we),
    .guard_wdata(guard_wdata), .irq_entry(irq_entry), .rst_entry(rst_entry),
    .flag_ack(flag_ack), .mem_we(mem_we), .irq(irq), .viol_flag(viol_flag)
  );

  function automatic logic in_win(input logic [7:0] b, input logic [13:0] o);
    return (b == 8'h20) && (o[13:12] == 2'b00);
  endfunction

  function automatic logic exp_we(input logic [7:0] b, input logic [13:0] o,
                                  input logic w, input logic [7:0] mp,
                                  input logic [15:0] g);
    return w && mp[b[7:5]] && (!in_win(b, o) || g[o[11:8]]);
  endfunction

  function automatic logic exp_viol(input logic [7:0] b, input logic [13:0] o,
                                    input logic w, input logic [7:0] mp,
                                    input logic [15:0] g);
    return w && mp[b[7:5]] && in_win(b, o) && !g[o[11:8]];
  endfunction

  task automatic check_bit(input string tag, input string what,
                           input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%b exp=%b", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input string tag);
    string wtag;
    #2;
    if (!wr_req) wtag = "R1";
    else if (!m_map[bank[7:5]]) wtag = "R3";
    else if (in_win(bank, offset)) wtag = "R4";
    else wtag = "R2";
    if (tag != "") wtag = tag;
    check_bit(wtag, "mem_we", mem_we, exp_we(bank, offset, wr_req, m_map, m_guard));
    check_bit("R7", "viol_flag", viol_flag, m_flag);
    check_bit("R7", "irq", irq, m_flag);
    @(posedge clk);
    if (exp_viol(bank, offset, wr_req, m_map, m_guard)) m_flag = 1'b1;
    else if (flag_ack) m_flag = 1'b0;
    if (map_we) m_map = map_wdata;
    if (irq_entry || rst_entry) m_guard = '1;
    else if (guard_we) m_guard = guard_wdata;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_req = 0; map_we = 0; guard_we = 0;
    irq_entry = 0; rst_entry = 0; flag_ack = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_map = 8'hFF; m_guard = 16'hFFFF; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R2 R5 reset state: everything writable, flag clear
    for (int b = 0; b < 256; b += 32) begin
      bank = b[7:0]; offset = 14'h0100; wr_req = 1; cyc("R2");
    end
    bank = 8'h20;
    for (int p = 0; p < 16; p++) begin
      offset = {2'b00, p[3:0], 8'h55}; wr_req = 1; cyc("R5");
    end
    idle(); cyc("R1");

    // R2 R3 region 3 read-only, silent
    map_we = 1; map_wdata = 8'hF7; cyc("R2");
    idle(); bank = 8'h60; offset = 14'h3FFF; wr_req = 1; cyc("R3");
    bank = 8'h7F; cyc("R3");
    bank = 8'h80; cyc("R2");
    idle(); cyc("R3");

    // R4 R6 R8 page 5 guarded
    guard_we = 1; guard_wdata = 16'hFFDF; cyc("R4");
    idle(); bank = 8'h20; offset = 14'h0510; wr_req = 1; cyc("R6");
    offset = 14'h0610; cyc("R8");
    offset = 14'h1510; cyc("R4");
    bank = 8'h21; offset = 14'h0510; cyc("R4");
    idle(); cyc("R6");

    // R7 sticky, then set-vs-ack priority, then clear
    repeat (3) cyc("R7");
    bank = 8'h20; offset = 14'h05FF; wr_req = 1; flag_ack = 1; cyc("R7");
    idle(); cyc("R7");
    flag_ack = 1; cyc("R7");
    idle(); cyc("R7");

    // R5 entry pulses beat a guard load
    guard_we = 1; guard_wdata = 16'h0000; irq_entry = 1; cyc("R5");
    idle(); bank = 8'h20; offset = 14'h0000; wr_req = 1; cyc("R5");
    guard_we = 1; guard_wdata = 16'h0000; wr_req = 0; cyc("R4");
    idle(); bank = 8'h20; offset = 14'h0F00; wr_req = 1; cyc("R6");
    idle(); rst_entry = 1; cyc("R5");
    idle(); bank = 8'h20; offset = 14'h0F00; wr_req = 1; cyc("R5");
    idle(); flag_ack = 1; cyc("R7");

    // R3 read-only region containing the guard window: silent block
    idle(); guard_we = 1; guard_wdata = 16'h0000; map_we = 1; map_wdata = 8'hFD; cyc("R2");
    idle(); bank = 8'h20; offset = 14'h0300; wr_req = 1; cyc("R3");
    idle(); cyc("R3");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      idle();
      bank   = ($urandom % 2) ? 8'h20 : 8'($urandom);
      offset = ($urandom % 2) ? {2'b00, 12'($urandom)} : 14'($urandom);
      wr_req = ($urandom % 4) != 0;
      if ($urandom % 16 == 0) begin
        map_we = 1; map_wdata = 8'($urandom) | (($urandom % 4) ? 8'h02 : 8'h00);
      end
      if ($urandom % 8 == 0) begin
        guard_we = 1; guard_wdata = 16'($urandom);
      end
      irq_entry = ($urandom % 32) == 0;
      rst_entry = ($urandom % 64) == 0;
      flag_ack  = ($urandom % 8) == 0;
      cyc("");
    end

    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule